// File: doc/BRIEF.md
# 8b/10b Transmit Character Front End

This block is the character-rate front end of a serial transmitter. It runs on the bit clock. A free-running divide-by-ten counter marks the single cycle in every ten when a new character is taken. In that cycle the block picks one 10-bit code and loads it into a shift register, which then sends the code one bit per clock, least significant bit first. The PLL and the line drivers sit outside this block.

The code comes from one of three sources. With `mode_bypass` high, the ten raw bits on `data_in` pass straight through. With `mode_bypass` low, the low byte of `data_in` is 8b/10b encoded under a running disparity, together with the control flag `is_k` and the flag `send_viol`. `send_viol` requests a deliberate code violation.

Pulling `bist_n` low starts a self-test generator, whatever the mode. The encoder then carries a start marker followed by a pseudo-random stream of data characters, and that stream contains deliberate violation symbols. The generator is a two-state machine. In `BS_IDLE` its output is the marker (comma character K28.5), and the transition to `BS_RUN` happens on the load that sends the marker. In `BS_RUN` its output is the next LFSR character, and the transition back to `BS_IDLE` happens as soon as `bist_n` returns high, after which the next load follows `mode_bypass` again.

Top module: `tx_char_front`

## Requirements
- R1: While `rst_n` is low and after reset, `tx_code` and `ser_out` are 0 and the running disparity is negative.
- R2: `chr_ack` is high for exactly one cycle in every ten, first in the ninth cycle after reset is released. A character load happens on the clock edge that ends a `chr_ack` cycle, and `tx_code` changes only on that edge.
- R3: During the ten cycles after a load, `ser_out` presents `tx_code[0]`, `tx_code[1]`, … `tx_code[9]` in that order.
- R4: With `mode_bypass`=1 and `bist_n`=1, the load copies `data_in[9:0]` to `tx_code` unchanged.
- R5: With `mode_bypass`=0, the load places the 8b/10b code of byte `data_in[7:0]` in `tx_code`. The code bits map as a=`tx_code[0]`, b..e=`[1..4]`, i=`[5]`, f..h=`[6..8]`, j=`[9]`. For example, D0.0 is abcdei fghj = 100111 0100 from negative disparity and 011000 1011 from positive disparity. D21.5 is 101010 1010. K28.5 (`is_k`=1, byte 0xBC) is 001111 1010 from negative disparity and 110000 0101 from positive disparity.
- R6: Every encoded character updates the running disparity. A code with six ones is sent only from negative disparity and makes it positive. A code with four ones is sent only from positive disparity and makes it negative. A code with five ones leaves it unchanged.
- R7: `send_viol`=1 in encoded mode sends the violation code `tx_code`=10'b00000_11111 (a..e high), and the running disparity is left unchanged.
- R8: `is_k`=1 with byte 0xE0, or with any byte that is not a valid control character, sends the violation code of R7. The valid control characters are K28.0–K28.7, K23.7, K27.7, K29.7 and K30.7.
- R9: With `bist_n`=0 the block encodes even when `mode_bypass`=1. The first load sends K28.5, and later loads send encoded LFSR characters (9-bit LFSR, x^9+x^5+1, seeded all ones).
- R10: In self-test, the character sent while the LFSR holds the all-ones state is the violation code. This is the first character after the marker, and it recurs every 511 characters.
- R11: After `bist_n` returns high, the next load again follows `mode_bypass`.
- R12: Bypass loads do not change the running disparity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_bypass | input | 1 | 1 = raw 10-bit pass-through, 0 = 8b/10b encode |
| bist_n | input | 1 | Active-low self-test enable |
| data_in | input | 10 | Raw code (bypass) or byte in bits 7:0 (encoded) |
| is_k | input | 1 | Byte is a control character |
| send_viol | input | 1 | Send the deliberate violation code |
| chr_ack | output | 1 | Inputs are taken at the end of this cycle |
| tx_code | output | 10 | Code most recently loaded into the shifter |
| ser_out | output | 1 | Serial bit stream, LSB first |

## Verification
A corrupted running-disparity register shows up on the very next encoded character. That character goes out with the wrong polarity, as a six-one code after a six-one code or a four-one code after a four-one code. A bench that tracks disparity from the code weights catches this within one character time. A miscounting bit counter moves `chr_ack` away from its one-in-ten spacing and garbles the serial order against `tx_code`, which is visible within ten cycles. A wrong self-test state or LFSR either drops the K28.5 marker or moves the violation symbol away from its fixed positions after the marker, which shows within 512 characters.

// File: rtl/tx_char_pkg.sv
package tx_char_pkg;

    localparam int CODE_W = 10;
    localparam int DATA_W = 8;
    localparam logic [CODE_W-1:0] VIOL_CODE = 10'b00000_11111;
    localparam logic [DATA_W-1:0] MARK_BYTE = 8'hBC;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_RUN  = 1'b1
    } bist_state_t;

    // 5b/6b sub-block, negative-disparity form, returned as {a,b,c,d,e,i}
    function automatic logic [5:0] enc6_neg(input logic [4:0] x);
        unique case (x)
            5'd0:  enc6_neg = 6'b100111;
            5'd1:  enc6_neg = 6'b011101;
            5'd2:  enc6_neg = 6'b101101;
            5'd3:  enc6_neg = 6'b110001;
            5'd4:  enc6_neg = 6'b110101;
            5'd5:  enc6_neg = 6'b101001;
            5'd6:  enc6_neg = 6'b011001;
            5'd7:  enc6_neg = 6'b111000;
            5'd8:  enc6_neg = 6'b111001;
            5'd9:  enc6_neg = 6'b100101;
            5'd10: enc6_neg = 6'b010101;
            5'd11: enc6_neg = 6'b110100;
            5'd12: enc6_neg = 6'b001101;
            5'd13: enc6_neg = 6'b101100;
            5'd14: enc6_neg = 6'b011100;
            5'd15: enc6_neg = 6'b010111;
            5'd16: enc6_neg = 6'b011011;
            5'd17: enc6_neg = 6'b100011;
            5'd18: enc6_neg = 6'b010011;
            5'd19: enc6_neg = 6'b110010;
            5'd20: enc6_neg = 6'b001011;
            5'd21: enc6_neg = 6'b101010;
            5'd22: enc6_neg = 6'b011010;
            5'd23: enc6_neg = 6'b111010;
            5'd24: enc6_neg = 6'b110011;
            5'd25: enc6_neg = 6'b100110;
            5'd26: enc6_neg = 6'b010110;
            5'd27: enc6_neg = 6'b110110;
            5'd28: enc6_neg = 6'b001110;
            5'd29: enc6_neg = 6'b101110;
            5'd30: enc6_neg = 6'b011110;
            default: enc6_neg = 6'b101011;
        endcase
    endfunction

    // 3b/4b sub-block, negative-disparity primary form, returned as {f,g,h,j}
    function automatic logic [3:0] enc4_neg(input logic [2:0] y);
        unique case (y)
            3'd0: enc4_neg = 4'b1011;
            3'd1: enc4_neg = 4'b1001;
            3'd2: enc4_neg = 4'b0101;
            3'd3: enc4_neg = 4'b1100;
            3'd4: enc4_neg = 4'b1101;
            3'd5: enc4_neg = 4'b1010;
            3'd6: enc4_neg = 4'b0110;
            default: enc4_neg = 4'b1110;
        endcase
    endfunction

endpackage

// File: rtl/tx_char_cnt.sv
module tx_char_cnt #(
    parameter int CHAR_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o
);
    localparam int CW = $clog2(CHAR_BITS);
    localparam logic [CW-1:0] LAST = CW'(CHAR_BITS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign load_o = (cnt_q == LAST);
endmodule

// File: rtl/tx_char_enc.sv
module tx_char_enc
    import tx_char_pkg::*;
(
    input  logic [DATA_W-1:0] byte_in,
    input  logic              k_in,
    input  logic              viol_in,
    input  logic              rd_in,     // 1 = positive
    output logic [CODE_W-1:0] code_out,  // bit 0 = a
    output logic              rd_out
);
    logic [4:0] x;
    logic [2:0] y;
    logic       k28, k_ok, bad, comp6, comp4, rd_mid, use_a7;
    logic [5:0] v6, s6;
    logic [3:0] v4, s4;
    logic [2:0] n6, n4;
    logic [CODE_W-1:0] msb_first;

    always_comb begin
        x      = byte_in[4:0];
        y      = byte_in[7:5];
        k28    = k_in && (x == 5'd28);
        k_ok   = k28 || (k_in && (y == 3'd7) &&
                 (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
        bad    = viol_in || (k_in && !k_ok);

        v6     = k28 ? 6'b001111 : enc6_neg(x);
        n6     = 3'($countones(v6));
        comp6  = rd_in && ((n6 != 3'd3) || (x == 5'd7 && !k28));
        s6     = comp6 ? ~v6 : v6;
        rd_mid = (n6 != 3'd3) ? ~rd_in : rd_in;

        use_a7 = (y == 3'd7) && (k_in ||
                 (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                 ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
        v4     = use_a7 ? 4'b0111 : enc4_neg(y);
        n4     = 3'($countones(v4));
        comp4  = rd_mid ? ((n4 != 3'd2) || (y == 3'd3))
                        : (k28 && (n4 == 3'd2) && (y != 3'd3));
        s4     = comp4 ? ~v4 : v4;

        msb_first = {s6, s4};
        for (int i = 0; i < CODE_W; i++) code_out[i] = msb_first[CODE_W-1-i];
        rd_out = (n4 != 3'd2) ? ~rd_mid : rd_mid;

        if (bad) begin
            code_out = VIOL_CODE;
            rd_out   = rd_in;
        end
    end
endmodule

// File: rtl/tx_char_bist.sv
module tx_char_bist
    import tx_char_pkg::*;
#(
    parameter int LFSR_W   = 9,
    parameter int LFSR_TAP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              bist_n,
    output logic [DATA_W-1:0] bist_byte,
    output logic              bist_k,
    output logic              bist_viol
);
    localparam logic [LFSR_W-1:0] SEED = '1;

    bist_state_t       state_q, state_d;
    logic [LFSR_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE: if (!bist_n && load) state_d = BS_RUN;
            BS_RUN:  if (bist_n)          state_d = BS_IDLE;
            default: state_d = BS_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            BS_RUN: begin
                bist_byte = lfsr_q[DATA_W-1:0];
                bist_k    = 1'b0;
                bist_viol = (lfsr_q == SEED);
            end
            default: begin
                bist_byte = MARK_BYTE;
                bist_k    = 1'b1;
                bist_viol = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q != BS_RUN) lfsr_q <= SEED;
        else if (load)
            lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_TAP-1]};
    end
endmodule

// File: rtl/tx_char_front.sv
module tx_char_front
    import tx_char_pkg::*;
#(
    parameter int LFSR_W   = 9,
    parameter int LFSR_TAP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_bypass,
    input  logic              bist_n,
    input  logic [CODE_W-1:0] data_in,
    input  logic              is_k,
    input  logic              send_viol,
    output logic              chr_ack,
    output logic [CODE_W-1:0] tx_code,
    output logic              ser_out
);
    logic              load, enc_mode, rd_q, enc_rd, b_k, b_v, sel_k, sel_v;
    logic [DATA_W-1:0] b_byte, sel_byte;
    logic [CODE_W-1:0] enc_code, code_nxt, code_q, shreg_q;

    tx_char_cnt #(.CHAR_BITS(CODE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_o(load)
    );

    tx_char_bist #(.LFSR_W(LFSR_W), .LFSR_TAP(LFSR_TAP)) u_bist (
        .clk(clk), .rst_n(rst_n), .load(load), .bist_n(bist_n),
        .bist_byte(b_byte), .bist_k(b_k), .bist_viol(b_v)
    );

    always_comb begin
        enc_mode = !mode_bypass || !bist_n;
        sel_byte = !bist_n ? b_byte : data_in[DATA_W-1:0];
        sel_k    = !bist_n ? b_k    : is_k;
        sel_v    = !bist_n ? b_v    : send_viol;
    end

    tx_char_enc u_enc (
        .byte_in(sel_byte), .k_in(sel_k), .viol_in(sel_v), .rd_in(rd_q),
        .code_out(enc_code), .rd_out(enc_rd)
    );

    assign code_nxt = enc_mode ? enc_code : data_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            shreg_q <= '0;
            rd_q    <= 1'b0;
        end else if (load) begin
            code_q  <= code_nxt;
            shreg_q <= code_nxt;
            if (enc_mode) rd_q <= enc_rd;
        end else begin
            shreg_q <= {1'b0, shreg_q[CODE_W-1:1]};
        end
    end

    assign chr_ack = load;
    assign tx_code = code_q;
    assign ser_out = shreg_q[0];
endmodule

// File: rtl/tx_char_front_chk.sv
module tx_char_front_chk
    import tx_char_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_bypass,
    input logic              bist_n,
    input logic [CODE_W-1:0] data_in,
    input logic              send_viol,
    input logic              chr_ack,
    input logic [CODE_W-1:0] tx_code,
    input logic              ser_out
);
    int unsigned gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n || chr_ack) gap_q <= 0;
        else                   gap_q <= gap_q + 1;
    end

    AST_ACK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        chr_ack |-> (gap_q == CODE_W - 1)); // R2
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !chr_ack |=> $stable(tx_code)); // R2
    AST_SER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        chr_ack |=> (ser_out == tx_code[0])); // R3
    AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_ack && mode_bypass && bist_n) |=> (tx_code == $past(data_in))); // R4
    AST_ENC_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_ack && (!mode_bypass || !bist_n)) |=>
        (($countones(tx_code) >= 4) && ($countones(tx_code) <= 6))); // R6
    AST_VIOL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_ack && !mode_bypass && bist_n && send_viol) |=> (tx_code == VIOL_CODE)); // R7
endmodule

bind tx_char_front tx_char_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_bypass(mode_bypass), .bist_n(bist_n),
    .data_in(data_in), .send_viol(send_viol), .chr_ack(chr_ack),
    .tx_code(tx_code), .ser_out(ser_out)
);

// File: tb/tx_char_front_tb.sv
`timescale 1ns/1ps
module tx_char_front_tb;
    logic       clk = 1'b0, rst_n = 1'b0, mode_bypass = 1'b0, bist_n = 1'b1;
    logic       is_k = 1'b0, send_viol = 1'b0;
    logic [9:0] data_in = '0;
    logic       chr_ack, ser_out;
    logic [9:0] tx_code;

    int   checks = 0, fails = 0;
    logic brd = 1'b0;           // bench disparity, 1 = positive
    logic [9:0] got_code, got_ser;
    bit   done = 0;

    localparam logic [9:0] VIOL = 10'b00000_11111;

    tx_char_front u_dut (
        .clk(clk), .rst_n(rst_n), .mode_bypass(mode_bypass), .bist_n(bist_n),
        .data_in(data_in), .is_k(is_k), .send_viol(send_viol),
        .chr_ack(chr_ack), .tx_code(tx_code), .ser_out(ser_out)
    );

    always #2 clk = ~clk;

    function automatic logic [9:0] ab(input logic [9:0] s);   // s written a..j
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = s[9-i];
        return r;
    endfunction

    function automatic logic [9:0] k285();
        return brd ? ab(10'b1100000101) : ab(10'b0011111010);
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic track(input string req, input logic [9:0] c);
        int n;
        n = $countones(c);
        checks++;
        if (n == 6 && !brd)     brd = 1'b1;
        else if (n == 4 && brd) brd = 1'b0;
        else if (n != 5) begin
            fails++;
            $display("FAIL %s disparity actual=%b(ones %0d) expected=legal from rd=%0d",
                     req, c, n, brd);
        end
    endtask

    task automatic xmit(input bit m, input bit b, input bit k, input bit v, input logic [9:0] d);
        mode_bypass = m; bist_n = b; is_k = k; send_viol = v; data_in = d;
        while (chr_ack !== 1'b1) @(negedge clk);
        @(negedge clk);
        got_code  = tx_code;
        got_ser[0] = ser_out;
        for (int i = 1; i < 10; i++) begin
            if (chr_ack !== 1'b0) check("R2", {9'b0, chr_ack}, 10'd0, "ack mid-char");
            @(negedge clk);
            got_ser[i] = ser_out;
        end
        check("R2", {9'b0, chr_ack}, 10'd1, "ack spacing");
        check("R3", got_ser, got_code, "serial order");
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", tx_code, 10'd0, "tx_code in reset");
        check("R1", {9'b0, ser_out}, 10'd0, "ser_out in reset");
        rst_n = 1'b1;
        n = 0;
        while (chr_ack !== 1'b1 && n < 20) begin @(negedge clk); n++; end
        check("R2", 10'(n), 10'd9, "first ack delay");
        check("R1", tx_code, 10'd0, "tx_code before first load");
        brd = 1'b0;
    endtask

    task automatic t_encode();
        xmit(0, 1, 1, 0, 10'h0BC); check("R5", got_code, ab(10'b0011111010), "K28.5 rd-"); track("R6", got_code);
        xmit(0, 1, 1, 0, 10'h0BC); check("R6", got_code, ab(10'b1100000101), "K28.5 rd+"); track("R6", got_code);
        xmit(0, 1, 0, 0, 10'h0B5); check("R5", got_code, ab(10'b1010101010), "D21.5"); track("R6", got_code);
        xmit(0, 1, 0, 0, 10'h000); check("R5", got_code, ab(10'b1001110100), "D0.0 rd-"); track("R6", got_code);
        xmit(0, 1, 1, 0, 10'h0BC); check("R6", got_code, ab(10'b0011111010), "K28.5 rd-"); track("R6", got_code);
        xmit(0, 1, 0, 0, 10'h000); check("R5", got_code, ab(10'b0110001011), "D0.0 rd+"); track("R6", got_code);
    endtask

    task automatic t_violation();
        xmit(0, 1, 0, 1, 10'h055); check("R7", got_code, VIOL, "send_viol");
        xmit(0, 1, 1, 0, 10'h0BC); check("R7", got_code, ab(10'b1100000101), "rd kept after viol"); track("R6", got_code);
        xmit(0, 1, 1, 0, 10'h0E0); check("R8", got_code, VIOL, "C0.7");
        xmit(0, 1, 1, 0, 10'h000); check("R8", got_code, VIOL, "invalid K0.0");
        xmit(0, 1, 1, 0, 10'h0BC); check("R8", got_code, ab(10'b0011111010), "rd kept after C0.7"); track("R6", got_code);
    endtask

    task automatic t_bypass();
        logic [9:0] kexp;
        xmit(1, 1, 1, 1, 10'h2B5); check("R4", got_code, 10'h2B5, "bypass 2B5");
        xmit(1, 1, 0, 0, 10'h3C0); check("R4", got_code, 10'h3C0, "bypass 3C0");
        kexp = k285();
        xmit(0, 1, 1, 0, 10'h0BC); check("R12", got_code, kexp, "rd after bypass"); track("R6", got_code);
    endtask

    task automatic t_bist();
        logic [9:0] kexp;
        bit bad_pos;
        kexp = k285();
        xmit(1, 0, 0, 0, 10'h3FF); check("R9", got_code, kexp, "marker in bypass"); track("R9", got_code);
        bad_pos = 0;
        for (int j = 0; j < 512; j++) begin
            xmit(1, 0, 0, 0, 10'h3FF);
            if (j == 0 || j == 511) begin
                check("R10", got_code, VIOL, $sformatf("viol at char %0d", j));
            end else begin
                if (got_code === VIOL && !bad_pos) begin
                    bad_pos = 1;
                    check("R10", got_code, 10'h000, $sformatf("unexpected viol at %0d", j));
                end
                track("R9", got_code);
            end
        end
        xmit(1, 1, 0, 0, 10'h155); check("R11", got_code, 10'h155, "bypass after BIST");
        kexp = k285();
        xmit(0, 1, 1, 0, 10'h0BC); check("R11", got_code, kexp, "encoded after BIST"); track("R6", got_code);
    endtask

    initial begin
        t_reset();
        t_encode();
        t_violation();
        t_bypass();
        t_bist();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule